// File: doc/BRIEF.md
# Euclidean Modular Divider over a Prime Field

This block computes z = x · y⁻¹ mod p for a fixed odd prime p that fits in K bits. It takes two K-bit operands and a one-cycle `start` strobe. It returns the quotient in the range 0..p−1 on `z`, and marks completion with a one-cycle `done` pulse. The unit is meant to sit beside a datapath that needs occasional field divisions, where area matters more than throughput.

Internally it runs an extended Euclidean remainder loop. Two K-bit registers start at p and y. Two wider signed cofactor registers start at 0 and x. Every pass through the loop runs three steps in turn. A sequential nonrestoring integer divider produces a quotient and a remainder. A shift-and-subtract unit forms the next cofactor. A single update cycle then shifts the register pairs. The loop ends when a comparator sees the running divisor reach 1. A sequential nonrestoring reducer then folds the signed cofactor into 0..p−1.

The sub-units are started by one-cycle strobes from a central state machine, and each answers with a one-cycle finish strobe. The latency depends on the number of remainder steps. That number is n, the number of times a, b := b, a mod b is applied, starting from (p, y), until b equals 1.

Top module: `gfp_div_euclid`

## Requirements
- R1: While reset is high and in the first cycle after it, `done` is 0 and `z` is 0.
- R2: For every K-bit x and every K-bit y with y mod p ≠ 0, the reported `z` satisfies z·y ≡ x (mod p) and 0 ≤ z < p.
- R3: With the start sampled at clock edge E0, `done` is 1 for exactly one cycle, after edge E0 + n·(2K+4) + K + 2, and is 0 after every other edge of the operation.
- R4: When y = 1 the loop body is never entered (n = 0). The result is x mod p, and `done` rises after edge E0 + K + 2.
- R5: A y at or above p (but not a multiple of p) gives a correct result. Its first remainder step has quotient 0 and counts toward n.
- R6: A `start` raised while an operation is in progress has no effect: the result value and the `done` timing of the running operation are unchanged.
- R7: `z` keeps its value from one completion until the next.
- R8: x = 0 gives z = 0 for any valid y.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock, rising edge |
| rst | input | 1 | Synchronous active-high reset |
| start | input | 1 | Begins an operation when the unit is idle |
| x | input | K | Dividend operand |
| y | input | K | Divisor operand, must not be a multiple of p |
| z | output | K | Registered result x·y⁻¹ mod p |
| done | output | 1 | One-cycle completion pulse, same cycle as a fresh `z` |

## Verification
For each operation, the bench computes n from the operands on its own with an integer remainder loop. From n it derives the exact edge, n·(2K+4)+K+2 after the start edge, at which `done` and a new `z` must show. The expected z comes from a brute-force search for the value whose product with y matches x modulo p. On every clock of the operation, the bench samples on the falling edge and compares `done` against that single due cycle. It compares `z` against the held previous result before that cycle and against the new one at it. A mid-operation start with different operands checks that neither the due cycle nor the value moves.

// File: rtl/gfp_div_pkg.sv
package gfp_div_pkg;

  // Controller states of the Euclidean loop
  typedef enum logic [2:0] {
    S_IDLE,
    S_CHECK,
    S_DIV,
    S_MUL,
    S_UPD,
    S_RED,
    S_FIN
  } gfp_state_e;

endpackage

// File: rtl/gfp_nr_divider.sv
// Sequential nonrestoring integer divider: num / den, K steps.
module gfp_nr_divider #(
  parameter int K = 8
) (
  input  logic         clk,
  input  logic         rst,
  input  logic         go,
  input  logic [K-1:0] num,
  input  logic [K-1:0] den,
  output logic         fin,
  output logic [K-1:0] quo,
  output logic [K-1:0] rem
);
  localparam int PW = K + 2;
  localparam int CW = $clog2(K + 1);

  logic [PW-1:0] pr;
  logic [K-1:0]  qr;
  logic [K-1:0]  dn;
  logic [CW-1:0] cnt;
  logic          run;
  logic [PW-1:0] sh;
  logic [PW-1:0] nx;

  // Partial remainder shifted with next dividend bit, then add or subtract
  always_comb begin
    sh = {pr[PW-2:0], qr[K-1]};
    nx = pr[PW-1] ? (sh + {2'b00, dn}) : (sh - {2'b00, dn});
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      pr  <= '0;
      qr  <= '0;
      dn  <= '0;
      cnt <= '0;
      run <= 1'b0;
      fin <= 1'b0;
    end else begin
      fin <= 1'b0;
      if (go) begin
        pr  <= '0;
        qr  <= num;
        dn  <= den;
        cnt <= '0;
        run <= 1'b1;
      end else if (run) begin
        pr  <= nx;
        qr  <= {qr[K-2:0], ~nx[PW-1]};
        cnt <= cnt + 1'b1;
        if (cnt == CW'(K - 1)) begin
          run <= 1'b0;
          fin <= 1'b1;
        end
      end
    end
  end

  assign quo = qr;
  // Final correction of a negative partial remainder
  assign rem = pr[PW-1] ? (pr[K-1:0] + dn) : pr[K-1:0];

endmodule

// File: rtl/gfp_mul_sub.sv
// Sequential acc = c - q*d, one multiplier bit per step, K steps.
module gfp_mul_sub #(
  parameter int K = 8,
  parameter int W = 18
) (
  input  logic         clk,
  input  logic         rst,
  input  logic         go,
  input  logic [K-1:0] q,
  input  logic [W-1:0] c,
  input  logic [W-1:0] d,
  output logic         fin,
  output logic [W-1:0] res
);
  localparam int CW = $clog2(K + 1);

  logic [W-1:0]  acc;
  logic [W-1:0]  md;
  logic [K-1:0]  qs;
  logic [CW-1:0] cnt;
  logic          run;

  always_ff @(posedge clk) begin
    if (rst) begin
      acc <= '0;
      md  <= '0;
      qs  <= '0;
      cnt <= '0;
      run <= 1'b0;
      fin <= 1'b0;
    end else begin
      fin <= 1'b0;
      if (go) begin
        acc <= c;
        md  <= d;
        qs  <= q;
        cnt <= '0;
        run <= 1'b1;
      end else if (run) begin
        if (qs[0]) acc <= acc - md;
        md  <= md << 1;
        qs  <= qs >> 1;
        cnt <= cnt + 1'b1;
        if (cnt == CW'(K - 1)) begin
          run <= 1'b0;
          fin <= 1'b1;
        end
      end
    end
  end

  assign res = acc;

endmodule

// File: rtl/gfp_nr_reducer.sv
// Sequential nonrestoring reduction of a signed W-bit value modulo P.
module gfp_nr_reducer #(
  parameter int K = 8,
  parameter int P = 239,
  parameter int W = 18
) (
  input  logic         clk,
  input  logic         rst,
  input  logic         go,
  input  logic [W-1:0] v,
  output logic         fin,
  output logic [K-1:0] zr
);
  localparam int CW = $clog2(K + 1);
  localparam logic [W-1:0] PW_P  = W'(P);
  localparam logic [W-1:0] P_TOP = PW_P << K;
  localparam logic [K-1:0] PK    = K'(P);

  logic [W-1:0]  rm;
  logic [W-1:0]  ps;
  logic [W-1:0]  mag;
  logic [CW-1:0] cnt;
  logic          run;
  logic          neg;
  logic [K-1:0]  pos;

  assign mag = v[W-1] ? (~v + 1'b1) : v;

  always_ff @(posedge clk) begin
    if (rst) begin
      rm  <= '0;
      ps  <= '0;
      cnt <= '0;
      run <= 1'b0;
      neg <= 1'b0;
      fin <= 1'b0;
    end else begin
      fin <= 1'b0;
      if (go) begin
        neg <= v[W-1];
        rm  <= mag - P_TOP;
        ps  <= P_TOP >> 1;
        cnt <= '0;
        run <= 1'b1;
      end else if (run) begin
        rm  <= rm[W-1] ? (rm + ps) : (rm - ps);
        ps  <= ps >> 1;
        cnt <= cnt + 1'b1;
        if (cnt == CW'(K - 1)) begin
          run <= 1'b0;
          fin <= 1'b1;
        end
      end
    end
  end

  // Remainder of the magnitude, then fold the sign back in
  assign pos = rm[K-1:0] + (rm[W-1] ? PK : '0);
  assign zr  = (neg && (pos != '0)) ? (PK - pos) : pos;

endmodule

// File: rtl/gfp_div_euclid.sv
module gfp_div_euclid
  import gfp_div_pkg::*;
#(
  parameter int K = 8,
  parameter int P = 239
) (
  input  logic         clk,
  input  logic         rst,
  input  logic         start,
  input  logic [K-1:0] x,
  input  logic [K-1:0] y,
  output logic [K-1:0] z,
  output logic         done
);
  // Signed cofactor width with headroom for q*d partial sums
  localparam int W = 2 * K + 2;

  gfp_state_e   st;
  logic [K-1:0] a_q, b_q;
  logic [W-1:0] c_q, d_q;
  logic         b_one;

  logic         div_go, div_fin;
  logic [K-1:0] div_quo, div_rem;
  logic         ms_go, ms_fin;
  logic [W-1:0] ms_res;
  logic         red_go, red_fin;
  logic [K-1:0] red_z;

  assign b_one  = (b_q == K'(1));
  assign div_go = (st == S_CHECK) && !b_one;
  assign red_go = (st == S_CHECK) && b_one;
  assign ms_go  = (st == S_DIV) && div_fin;

  gfp_nr_divider #(.K(K)) u_div (
    .clk (clk),
    .rst (rst),
    .go  (div_go),
    .num (a_q),
    .den (b_q),
    .fin (div_fin),
    .quo (div_quo),
    .rem (div_rem)
  );

  gfp_mul_sub #(.K(K), .W(W)) u_ms (
    .clk (clk),
    .rst (rst),
    .go  (ms_go),
    .q   (div_quo),
    .c   (c_q),
    .d   (d_q),
    .fin (ms_fin),
    .res (ms_res)
  );

  gfp_nr_reducer #(.K(K), .P(P), .W(W)) u_red (
    .clk (clk),
    .rst (rst),
    .go  (red_go),
    .v   (d_q),
    .fin (red_fin),
    .zr  (red_z)
  );

  always_ff @(posedge clk) begin
    if (rst) begin
      st   <= S_IDLE;
      a_q  <= '0;
      b_q  <= '0;
      c_q  <= '0;
      d_q  <= '0;
      z    <= '0;
      done <= 1'b0;
    end else begin
      done <= 1'b0;
      case (st)
        S_IDLE: begin
          if (start) begin
            a_q <= K'(P);
            b_q <= y;
            c_q <= '0;
            d_q <= {{(W-K){1'b0}}, x};
            st  <= S_CHECK;
          end
        end
        S_CHECK: st <= b_one ? S_RED : S_DIV;
        S_DIV:   if (div_fin) st <= S_MUL;
        S_MUL:   if (ms_fin) st <= S_UPD;
        S_UPD: begin
          a_q <= b_q;
          b_q <= div_rem;
          c_q <= d_q;
          d_q <= ms_res;
          st  <= S_CHECK;
        end
        S_RED: begin
          if (red_fin) begin
            z    <= red_z;
            done <= 1'b1;
            st   <= S_FIN;
          end
        end
        S_FIN:   st <= S_IDLE;
        default: st <= S_IDLE;
      endcase
    end
  end

endmodule

// File: rtl/gfp_div_euclid_chk.sv
module gfp_div_euclid_chk
  import gfp_div_pkg::*;
#(
  parameter int K = 8,
  parameter int P = 239
) (
  input logic         clk,
  input logic         rst,
  input logic         start,
  input logic         done,
  input logic [K-1:0] z,
  input gfp_state_e   st,
  input logic [K-1:0] b_q,
  input logic         div_fin,
  input logic         ms_fin,
  input logic         red_fin
);

  p_done_pulse_r3: assert property (@(posedge clk) disable iff (rst)
    done |=> !done);

  p_one_finish_r3: assert property (@(posedge clk) disable iff (rst)
    $onehot0({div_fin, ms_fin, red_fin}));

  p_z_range_r2: assert property (@(posedge clk) disable iff (rst)
    done |-> (z < K'(P)));

  p_divisor_nz_r2: assert property (@(posedge clk) disable iff (rst)
    (st == S_CHECK) |-> (b_q != '0));

  p_z_hold_r7: assert property (@(posedge clk) disable iff (rst)
    !done |-> $stable(z));

  p_busy_start_r6: assert property (@(posedge clk) disable iff (rst)
    (start && (st == S_DIV)) |=> (st != S_CHECK) && $stable(b_q));

endmodule

bind gfp_div_euclid gfp_div_euclid_chk #(.K(K), .P(P)) u_chk (
  .clk     (clk),
  .rst     (rst),
  .start   (start),
  .done    (done),
  .z       (z),
  .st      (st),
  .b_q     (b_q),
  .div_fin (div_fin),
  .ms_fin  (ms_fin),
  .red_fin (red_fin)
);

// File: tb/sim_gfp_div_euclid.sv
module sim_gfp_div_euclid;
  localparam int K = 8;
  localparam int P = 239;
  localparam time CLK_PERIOD = 10;
  localparam int WATCHDOG = 150000;

  logic         clk = 1'b0;
  logic         rst;
  logic         start;
  logic [K-1:0] x, y;
  logic [K-1:0] z;
  logic         done;

  int n_checks = 0;
  int n_fail   = 0;
  int cycles   = 0;
  int prev_z   = 0;
  int unsigned seed = 32'h1234_5678;

  gfp_div_euclid #(.K(K), .P(P)) u0 (
    .clk   (clk),
    .rst   (rst),
    .start (start),
    .x     (x),
    .y     (y),
    .z     (z),
    .done  (done)
  );

  always #(CLK_PERIOD/2) clk = ~clk;

  always @(posedge clk) begin
    cycles <= cycles + 1;
    if (cycles > WATCHDOG) begin
      n_checks = n_checks + 1;
      n_fail   = n_fail + 1;
      $display("FAIL watchdog: act=%0d cycles exp<=%0d", cycles, WATCHDOG);
      $display("  %0d/%0d checks passed", n_checks - n_fail, n_checks);
      $finish;
    end
  end

  task automatic check(input bit ok, input string req, input int act, input int exp);
    n_checks = n_checks + 1;
    if (!ok) begin
      n_fail = n_fail + 1;
      $display("FAIL %s: act=%0d exp=%0d (t=%0t)", req, act, exp, $time);
    end
  endtask

  // Reference: field quotient by exhaustive search
  function automatic int ref_quot(input int xi, input int yi);
    for (int t = 0; t < P; t++)
      if (((t * yi) % P) == (xi % P)) return t;
    return -1;
  endfunction

  // Reference: number of remainder steps from (p, y) until the divisor is 1
  function automatic int ref_steps(input int yi);
    int ra = P;
    int rb = yi;
    int n  = 0;
    while (rb != 1) begin
      int t = ra % rb;
      ra = rb;
      rb = t;
      n++;
    end
    return n;
  endfunction

  function automatic int next_rand();
    seed = seed * 32'd1103515245 + 32'd12345;
    return int'(seed >> 16);
  endfunction

  // One operation, compared against the model on every cycle
  task automatic run_op(input int xi, input int yi, input string ztag, input bit poke);
    int zexp = ref_quot(xi, yi);
    int lat  = ref_steps(yi) * (2 * K + 4) + K + 2;
    @(negedge clk);
    x = K'(xi);
    y = K'(yi);
    start = 1'b1;
    @(negedge clk);             // edge E0 has passed
    start = 1'b0;
    check(done == 1'b0, "R3", int'(done), 0);
    for (int i = 1; i <= lat + 2; i++) begin
      if (poke && i == 3) begin
        start = 1'b1;
        x = K'(xi ^ 8'h5A);
        y = K'((yi % 200) + 2);
      end
      if (poke && i == 4) begin
        start = 1'b0;
        x = K'(xi);
        y = K'(yi);
      end
      @(negedge clk);
      if (i == lat) begin
        check(done == 1'b1, poke ? "R6" : "R3", int'(done), 1);
        check(int'(z) == zexp, ztag, int'(z), zexp);
      end else begin
        check(done == 1'b0, poke ? "R6" : "R3", int'(done), 0);
        if (i < lat) check(int'(z) == prev_z, "R7", int'(z), prev_z);
        else         check(int'(z) == zexp, "R7", int'(z), zexp);
      end
    end
    prev_z = zexp;
  endtask

  initial begin
    rst = 1'b1;
    start = 1'b0;
    x = '0;
    y = '0;
    repeat (3) @(negedge clk);
    check(done == 1'b0, "R1", int'(done), 0);
    check(z == '0, "R1", int'(z), 0);
    rst = 1'b0;
    @(negedge clk);
    check(done == 1'b0, "R1", int'(done), 0);
    check(z == '0, "R1", int'(z), 0);

    run_op(100, 1, "R4", 1'b0);    // loop skipped, x < p
    run_op(250, 1, "R4", 1'b0);    // loop skipped, x >= p
    run_op(0, 37, "R8", 1'b0);     // zero dividend
    run_op(5, 3, "R2", 1'b0);
    run_op(1, 238, "R2", 1'b0);    // y = p-1
    run_op(200, 250, "R5", 1'b0);  // y above p
    run_op(255, 255, "R5", 1'b0);
    run_op(77, 144, "R6", 1'b1);   // start raised mid-run
    run_op(13, 2, "R2", 1'b0);

    for (int k = 0; k < 30; k++) begin
      int xr = next_rand() % 256;
      int yr = (next_rand() % 255) + 1;
      if (yr == P) yr = 1;
      run_op(xr, yr, "R2", 1'b0);
    end

    $display("  %0d/%0d checks passed", n_checks - n_fail, n_checks);
    $finish;
  end

endmodule